// File: doc/BRIEF.md
# Block-Transfer Serial Register Slave

This block is a slave on a two-wire serial bus (standard-mode I2C) that gives a host write and readback access to a small bank of 8-bit control registers. Those registers drive the surrounding logic as parallel outputs. The slave has no internal register pointer. Every transfer, whether a write or a read, starts at register 0 and moves upward one register per byte.

A write carries two leading bytes after the address: a command byte and a count byte. The slave acknowledges both and discards them. The bytes that follow land in registers 0, 1, 2 and so on. A read first returns a byte count, which is a constant equal to the number of registers, and then the register contents in ascending order.

The serial clock and data lines are sampled by the system clock through synchronizers. The data line is driven only as an open-drain pull-low enable.

Top module: `i2c_blk_regslave`

## Requirements
- R1: The slave answers only the 7-bit address 1101001: address byte 0xD2 selects a write and 0xD3 selects a read, and the slave pulls SDA low in the acknowledge slot of a matching address byte.
- R2: When the address does not match, the slave leaves SDA released (the master sees NACK) until the next START, and no register changes.
- R3: Each byte travels most significant bit first, in both directions.
- R4: In a write, the first two bytes after the address are acknowledged and discarded, and the following bytes are stored into register 0, 1, 2 and onward.
- R5: In a read, the first byte returned is the register count (6), followed by register 0, 1 and onward.
- R6: After reset, register 0 holds 0x02 and registers 1 to 5 hold 0x00.
- R7: Write bytes addressed beyond register 5 are acknowledged and change no register.
- R8: Read bytes beyond register 5 return 0xFF.
- R9: When the master does not acknowledge a read byte, the slave releases SDA and drives nothing until the next START.
- R10: A START at any point, including a repeated START, begins a new transfer that again starts at register 0, and a STOP returns the slave to idle.
- R11: The slave acknowledges every byte of a write after a matching address by pulling SDA low during the ninth clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Serial clock line as seen on the bus |
| sda_in | input | 1 | Serial data line as seen on the bus |
| sda_pull | output | 1 | 1 = pull SDA low; 0 = release |
| reg_bank | output | NUM_REGS*8 | Register contents, register k at bits 8k+7 down to 8k |

## Verification
The bench writes random byte counts from none up to past the end of the bank. It then reads the whole bank back plus two extra bytes. A slave that stored the command or count byte would show every register shifted by one or two places. A slave that wrapped past the last register would overwrite register 0, and one that returned stale data past the end would send a value other than 0xFF. Directed cases cover four more faults:
- A wrong address must get no acknowledge and leave the bank untouched.
- A repeated START in the middle of a write must restart at register 0 rather than continue at register 1.
- A master NACK must leave the line released even while the master keeps clocking.
- Single-bit patterns written to register 0 expose a bit order that has been reversed.

// File: rtl/i2cbs_pkg.sv
package i2cbs_pkg;

   typedef enum logic [2:0] {
      ST_IDLE   = 3'd0,
      ST_RX     = 3'd1,
      ST_RX_ACK = 3'd2,
      ST_TX     = 3'd3,
      ST_TX_ACK = 3'd4,
      ST_SKIP   = 3'd5
   } eng_state_t;

   localparam int unsigned BYTE_W = 8;

endpackage

// File: rtl/i2cbs_sync.sv
module i2cbs_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_in,
   input  logic sda_in,
   output logic scl_s,
   output logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("i2cbs_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] scl_ff;
   logic [STAGES-1:0] sda_ff;
   logic              scl_d;
   logic              sda_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_ff <= '1;
         sda_ff <= '1;
         scl_d  <= 1'b1;
         sda_d  <= 1'b1;
      end else begin
         scl_ff <= {scl_ff[STAGES-2:0], scl_in};
         sda_ff <= {sda_ff[STAGES-2:0], sda_in};
         scl_d  <= scl_ff[STAGES-1];
         sda_d  <= sda_ff[STAGES-1];
      end
   end

   assign scl_s     = scl_ff[STAGES-1];
   assign sda_s     = sda_ff[STAGES-1];
   assign scl_rise  = scl_s & ~scl_d;
   assign scl_fall  = ~scl_s & scl_d;
   assign start_det = scl_s & scl_d & sda_d & ~sda_s;
   assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;

endmodule

// File: rtl/i2cbs_regbank.sv
module i2cbs_regbank #(
   parameter int unsigned NUM_REGS  = 6,
   parameter int unsigned IDX_W     = 4,
   parameter logic [7:0]  REG0_INIT = 8'h02,
   parameter logic [7:0]  REGN_INIT = 8'h00,
   parameter logic [7:0]  FILL_BYTE = 8'hFF
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_en,
   input  logic [IDX_W-1:0]      wr_idx,
   input  logic [7:0]            wr_data,
   input  logic [IDX_W-1:0]      rd_idx,
   output logic [7:0]            rd_data,
   output logic [NUM_REGS*8-1:0] bank_o
);

   generate
      if (NUM_REGS < 1 || NUM_REGS > 250) begin : g_bad_regs
         $error("i2cbs_regbank: NUM_REGS out of range");
      end
      if ((1 << IDX_W) <= NUM_REGS) begin : g_bad_idx
         $error("i2cbs_regbank: IDX_W too narrow");
      end
   endgenerate

   logic [7:0] regs [NUM_REGS];

   genvar g;
   generate
      for (g = 0; g < NUM_REGS; g++) begin : g_reg
         localparam logic [7:0] INIT = (g == 0) ? REG0_INIT : REGN_INIT;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               regs[g] <= INIT;
            end else if (wr_en && (wr_idx == IDX_W'(g))) begin
               regs[g] <= wr_data;
            end
         end
         assign bank_o[g*8 +: 8] = regs[g];
      end
   endgenerate

   always_comb begin
      rd_data = FILL_BYTE;
      for (int k = 0; k < NUM_REGS; k++) begin
         if (rd_idx == IDX_W'(k)) begin
            rd_data = regs[k];
         end
      end
   end

endmodule

// File: rtl/i2cbs_engine.sv
module i2cbs_engine
   import i2cbs_pkg::*;
#(
   parameter int unsigned NUM_REGS   = 6,
   parameter int unsigned IDX_W      = 4,
   parameter int unsigned HDR_BYTES  = 2,
   parameter logic [6:0]  DEV_ADDR   = 7'b1101001,
   parameter logic [7:0]  READ_COUNT = 8'd6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sda_s,
   input  logic             scl_rise,
   input  logic             scl_fall,
   input  logic             start_det,
   input  logic             stop_det,
   input  logic [7:0]       rd_data,
   output logic [IDX_W-1:0] rd_idx,
   output logic             wr_en,
   output logic [IDX_W-1:0] wr_idx,
   output logic [7:0]       wr_data,
   output logic             sda_pull,
   output eng_state_t       state
);

   localparam logic [IDX_W-1:0] HDR_L  = IDX_W'(HDR_BYTES);
   localparam logic [IDX_W-1:0] CNT_MX = '1;

   generate
      if ((1 << IDX_W) < NUM_REGS + HDR_BYTES + 2) begin : g_bad_w
         $error("i2cbs_engine: IDX_W too narrow for header plus bank");
      end
   endgenerate

   logic [7:0]       shreg;
   logic [7:0]       txsh;
   logic [2:0]       bitcnt;
   logic             got8;
   logic             is_addr;
   logic             is_read;
   logic             mnack;
   logic [IDX_W-1:0] bcnt;
   logic [IDX_W-1:0] rcnt;
   logic [7:0]       next_tx;

   assign rd_idx  = rcnt - IDX_W'(1);
   assign next_tx = (rcnt == '0) ? READ_COUNT : rd_data;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         shreg   <= '0;
         txsh    <= '0;
         bitcnt  <= '0;
         got8    <= 1'b0;
         is_addr <= 1'b0;
         is_read <= 1'b0;
         mnack   <= 1'b0;
         bcnt    <= '0;
         rcnt    <= '0;
         wr_en   <= 1'b0;
         wr_idx  <= '0;
         wr_data <= '0;
      end else begin
         wr_en <= 1'b0;
         if (start_det) begin
            state   <= ST_RX;
            bitcnt  <= '0;
            got8    <= 1'b0;
            is_addr <= 1'b1;
            is_read <= 1'b0;
            bcnt    <= '0;
            rcnt    <= '0;
         end else if (stop_det) begin
            state <= ST_IDLE;
         end else begin
            unique case (state)
               ST_RX: begin
                  if (scl_rise) begin
                     shreg  <= {shreg[6:0], sda_s};
                     bitcnt <= bitcnt + 3'd1;
                     if (bitcnt == 3'd7) begin
                        got8 <= 1'b1;
                     end
                  end else if (scl_fall && got8) begin
                     got8 <= 1'b0;
                     if (is_addr) begin
                        if (shreg[7:1] == DEV_ADDR) begin
                           is_read <= shreg[0];
                           state   <= ST_RX_ACK;
                        end else begin
                           state <= ST_SKIP;
                        end
                     end else begin
                        state <= ST_RX_ACK;
                        if (bcnt >= HDR_L) begin
                           wr_en   <= 1'b1;
                           wr_idx  <= bcnt - HDR_L;
                           wr_data <= shreg;
                        end
                        if (bcnt != CNT_MX) begin
                           bcnt <= bcnt + IDX_W'(1);
                        end
                     end
                  end
               end
               ST_RX_ACK: begin
                  if (scl_fall) begin
                     bitcnt  <= '0;
                     is_addr <= 1'b0;
                     if (is_addr && is_read) begin
                        state <= ST_TX;
                        txsh  <= next_tx;
                        if (rcnt != CNT_MX) begin
                           rcnt <= rcnt + IDX_W'(1);
                        end
                     end else begin
                        state <= ST_RX;
                     end
                  end
               end
               ST_TX: begin
                  if (scl_fall) begin
                     if (bitcnt == 3'd7) begin
                        state <= ST_TX_ACK;
                     end else begin
                        txsh   <= {txsh[6:0], 1'b0};
                        bitcnt <= bitcnt + 3'd1;
                     end
                  end
               end
               ST_TX_ACK: begin
                  if (scl_rise) begin
                     mnack <= sda_s;
                  end else if (scl_fall) begin
                     if (mnack) begin
                        state <= ST_SKIP;
                     end else begin
                        state  <= ST_TX;
                        bitcnt <= '0;
                        txsh   <= next_tx;
                        if (rcnt != CNT_MX) begin
                           rcnt <= rcnt + IDX_W'(1);
                        end
                     end
                  end
               end
               default: begin
               end
            endcase
         end
      end
   end

   always_comb begin
      unique case (state)
         ST_RX_ACK: sda_pull = 1'b1;
         ST_TX:     sda_pull = ~txsh[7];
         default:   sda_pull = 1'b0;
      endcase
   end

endmodule

// File: rtl/i2c_blk_regslave.sv
module i2c_blk_regslave
   import i2cbs_pkg::*;
#(
   parameter int unsigned NUM_REGS    = 6,
   parameter int unsigned HDR_BYTES   = 2,
   parameter int unsigned SYNC_STAGES = 2,
   parameter logic [6:0]  DEV_ADDR    = 7'b1101001,
   parameter logic [7:0]  REG0_INIT   = 8'h02,
   parameter logic [7:0]  REGN_INIT   = 8'h00,
   parameter logic [7:0]  FILL_BYTE   = 8'hFF
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  scl_in,
   input  logic                  sda_in,
   output logic                  sda_pull,
   output logic [NUM_REGS*8-1:0] reg_bank
);

   localparam int unsigned BC_W = $clog2(NUM_REGS + HDR_BYTES + 2);

   logic             scl_s;
   logic             sda_s;
   logic             scl_rise;
   logic             scl_fall;
   logic             start_det;
   logic             stop_det;
   logic [7:0]       rd_data;
   logic [BC_W-1:0]  rd_idx;
   logic             wr_en;
   logic [BC_W-1:0]  wr_idx;
   logic [7:0]       wr_data;
   eng_state_t       eng_state;

   i2cbs_sync #(
      .STAGES(SYNC_STAGES)
   ) u_sync (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_in    (scl_in),
      .sda_in    (sda_in),
      .scl_s     (scl_s),
      .sda_s     (sda_s),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .start_det (start_det),
      .stop_det  (stop_det)
   );

   i2cbs_engine #(
      .NUM_REGS   (NUM_REGS),
      .IDX_W      (BC_W),
      .HDR_BYTES  (HDR_BYTES),
      .DEV_ADDR   (DEV_ADDR),
      .READ_COUNT (8'(NUM_REGS))
   ) u_engine (
      .clk       (clk),
      .rst_n     (rst_n),
      .sda_s     (sda_s),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .start_det (start_det),
      .stop_det  (stop_det),
      .rd_data   (rd_data),
      .rd_idx    (rd_idx),
      .wr_en     (wr_en),
      .wr_idx    (wr_idx),
      .wr_data   (wr_data),
      .sda_pull  (sda_pull),
      .state     (eng_state)
   );

   i2cbs_regbank #(
      .NUM_REGS  (NUM_REGS),
      .IDX_W     (BC_W),
      .REG0_INIT (REG0_INIT),
      .REGN_INIT (REGN_INIT),
      .FILL_BYTE (FILL_BYTE)
   ) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_idx  (wr_idx),
      .wr_data (wr_data),
      .rd_idx  (rd_idx),
      .rd_data (rd_data),
      .bank_o  (reg_bank)
   );

endmodule

// File: rtl/i2cbs_checker.sv
module i2cbs_checker
   import i2cbs_pkg::*;
#(
   parameter int unsigned NUM_REGS = 6,
   parameter int unsigned IDX_W    = 4
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  scl_s,
   input logic                  sda_pull,
   input logic                  stop_det,
   input logic                  wr_en,
   input logic [IDX_W-1:0]      wr_idx,
   input eng_state_t            state,
   input logic [NUM_REGS*8-1:0] regs
);

   // R2 and R9: no drive while idle or skipping a transfer
   assert_release_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE || state == ST_SKIP) |-> !sda_pull);

   // R3: data line only changes while the clock is low
   assert_change_scl_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sda_pull) |-> !scl_s);

   // R4: bank changes only through a write strobe
   assert_hold_regs_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(regs));

   // R7: strobe past the last register leaves the bank alone
   assert_beyond_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && (wr_idx >= IDX_W'(NUM_REGS))) |=> $stable(regs));

   // R10: STOP lands in idle
   assert_stop_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
      stop_det |=> (state == ST_IDLE));

   // R11: pull only in an acknowledge slot or a transmit bit
   assert_pull_phase_R11: assert property (@(posedge clk) disable iff (!rst_n)
      sda_pull |-> (state == ST_RX_ACK || state == ST_TX));

endmodule

bind i2c_blk_regslave i2cbs_checker #(
   .NUM_REGS (NUM_REGS),
   .IDX_W    (BC_W)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .scl_s    (scl_s),
   .sda_pull (sda_pull),
   .stop_det (stop_det),
   .wr_en    (wr_en),
   .wr_idx   (wr_idx),
   .state    (eng_state),
   .regs     (reg_bank)
);

// File: tb/test_i2c_blk_regslave.sv
module test_i2c_blk_regslave;

   localparam int  CLK_PERIOD = 10;
   localparam int  NREG = 6;
   localparam int  QT   = 5;
   localparam int  HT   = 10;
   localparam logic [7:0] WR_ADDR = 8'hD2;
   localparam logic [7:0] RD_ADDR = 8'hD3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic m_scl = 1'b1;
   logic m_sda = 1'b1;
   logic sda_pull;
   logic [NREG*8-1:0] reg_bank;
   wire  sda_line = m_sda & ~sda_pull;

   int errors = 0;
   int checks = 0;
   bit finished = 1'b0;
   logic [7:0] model [NREG];

   always #(CLK_PERIOD/2) clk = ~clk;

   i2c_blk_regslave i_i2c_blk_regslave (
      .clk      (clk),
      .rst_n    (rst_n),
      .scl_in   (m_scl),
      .sda_in   (sda_line),
      .sda_pull (sda_pull),
      .reg_bank (reg_bank)
   );

   task automatic wait_clk(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
      end
   endtask

   function automatic logic [7:0] exp_read(input int pos);
      if (pos == 0) return 8'(NREG);
      if (pos - 1 < NREG) return model[pos-1];
      return 8'hFF;
   endfunction

   task automatic bus_start();
      m_sda = 1'b1; wait_clk(QT);
      m_scl = 1'b1; wait_clk(QT);
      m_sda = 1'b0; wait_clk(QT);
      m_scl = 1'b0; wait_clk(QT);
   endtask

   task automatic bus_stop();
      m_sda = 1'b0; wait_clk(QT);
      m_scl = 1'b1; wait_clk(QT);
      m_sda = 1'b1; wait_clk(QT);
   endtask

   task automatic send_byte(input logic [7:0] b, output logic acked);
      for (int i = 7; i >= 0; i--) begin
         m_sda = b[i]; wait_clk(QT);
         m_scl = 1'b1; wait_clk(HT);
         m_scl = 1'b0; wait_clk(QT);
      end
      m_sda = 1'b1; wait_clk(QT);
      m_scl = 1'b1; wait_clk(HT/2);
      acked = ~sda_line;
      wait_clk(HT/2);
      m_scl = 1'b0; wait_clk(QT);
   endtask

   task automatic recv_byte(input logic give_ack, output logic [7:0] b);
      m_sda = 1'b1;
      for (int i = 7; i >= 0; i--) begin
         wait_clk(QT);
         m_scl = 1'b1; wait_clk(HT/2);
         b[i] = sda_line;
         wait_clk(HT/2);
         m_scl = 1'b0;
      end
      m_sda = ~give_ack; wait_clk(QT);
      m_scl = 1'b1; wait_clk(HT);
      m_scl = 1'b0; wait_clk(QT);
      m_sda = 1'b1;
   endtask

   task automatic do_write(input int n, input logic [7:0] data [16], input string tag);
      logic ack;
      bus_start();
      send_byte(WR_ADDR, ack); chk({tag, " R1 addr ack"}, 8'(ack), 8'h01);
      send_byte(8'h00, ack);   chk({tag, " R4 cmd ack"}, 8'(ack), 8'h01);
      send_byte(8'(n), ack);   chk({tag, " R4 count ack"}, 8'(ack), 8'h01);
      for (int i = 0; i < n; i++) begin
         send_byte(data[i], ack);
         chk({tag, " R11 data ack"}, 8'(ack), 8'h01);
         if (i < NREG) model[i] = data[i];
      end
      bus_stop();
   endtask

   task automatic check_bank(input string tag);
      for (int i = 0; i < NREG; i++) begin
         chk(tag, reg_bank[i*8 +: 8], model[i]);
      end
   endtask

   task automatic do_read(input int n, input string tag);
      logic ack;
      logic [7:0] b;
      bus_start();
      send_byte(RD_ADDR, ack); chk({tag, " R1 read addr ack"}, 8'(ack), 8'h01);
      for (int i = 0; i < n; i++) begin
         recv_byte(i != n - 1, b);
         if (i == 0)            chk({tag, " R5 count byte"}, b, exp_read(i));
         else if (i - 1 < NREG) chk({tag, " R5 data byte"}, b, exp_read(i));
         else                   chk({tag, " R8 fill byte"}, b, exp_read(i));
      end
      bus_stop();
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      if (!finished) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      logic [7:0] d [16];
      logic ack;
      logic [7:0] b;
      void'($urandom(32'h5EED_1234));
      model[0] = 8'h02;
      for (int i = 1; i < NREG; i++) model[i] = 8'h00;
      wait_clk(5);
      rst_n = 1'b1;
      wait_clk(5);
      check_bank("R6 reset value");
      chk("R6 no drive after reset", 8'(sda_pull), 8'h00);

      // R3: single-bit patterns into register 0
      d[0] = 8'h01; do_write(1, d, "msb");
      chk("R3 bit order 01", reg_bank[7:0], 8'h01);
      d[0] = 8'h80; do_write(1, d, "msb");
      chk("R3 bit order 80", reg_bank[7:0], 8'h80);

      // R2: wrong address gets NACK and changes nothing
      bus_start();
      send_byte(8'hD4, ack); chk("R2 wrong addr nack", 8'(ack), 8'h00);
      send_byte(8'h00, ack); chk("R2 stays released", 8'(ack), 8'h00);
      send_byte(8'h01, ack);
      send_byte(8'h5A, ack); chk("R2 data ignored ack", 8'(ack), 8'h00);
      bus_stop();
      check_bank("R2 bank untouched");

      // R7 and R8: write past the end, read past the end
      for (int i = 0; i < 8; i++) d[i] = 8'(8'h30 + i);
      do_write(8, d, "over");
      check_bank("R7 over-length write");
      do_read(NREG + 3, "over");

      // R10: repeated START mid-write restarts at register 0
      bus_start();
      send_byte(WR_ADDR, ack); send_byte(8'h00, ack); send_byte(8'h02, ack);
      send_byte(8'hA1, ack);
      bus_start();
      send_byte(WR_ADDR, ack); send_byte(8'h00, ack); send_byte(8'h02, ack);
      send_byte(8'hB2, ack);
      bus_stop();
      model[0] = 8'hB2;
      chk("R10 restart reg0", reg_bank[7:0], 8'hB2);
      chk("R10 reg1 untouched", reg_bank[15:8], model[1]);

      // R9: master NACK after two bytes, slave stays released
      bus_start();
      send_byte(RD_ADDR, ack);
      recv_byte(1'b1, b); chk("R9 count", b, 8'(NREG));
      recv_byte(1'b0, b); chk("R9 first data", b, model[0]);
      recv_byte(1'b1, b); chk("R9 released after nack", b, 8'hFF);
      bus_stop();

      // random block writes followed by full readback
      for (int t = 0; t < 14; t++) begin
         int n;
         n = int'($urandom_range(0, 8));
         for (int i = 0; i < 16; i++) d[i] = 8'($urandom);
         do_write(n, d, "rand");
         check_bank("R4 random write");
         do_read(NREG + 3, "rand");
      end

      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule